// File: doc/BRIEF.md
# Cache Line Fill Read Assembler

This block collects the read data that answers a data-cache miss. The bus is 64 bits wide, but the slave that answers may be 32 or 64 bits wide. A request is either one word or a full eight-word line. A narrow slave drives the same word on both halves of the bus, so the block picks one half using the returned word address. A wide slave sends an aligned doubleword, and the block takes both words in the same transfer.

Each accepted acknowledge writes its word or words into the line slots named by the returned word address. The line therefore fills correctly in any order, and with any number of idle cycles between transfers. A single-word request does not touch the line. It updates a separate result register, in which the bytes that are not enabled read as zero. A one-cycle done pulse follows the last expected acknowledge.

Top module: `lfill_assembler`

## Requirements
- R1: While reset is held and in the first cycle after it, `done` is 0, `single_word` is 0 and every slot of `line_data` is 0.
- R2: Read data is captured only at a clock edge where `rd_ack` is 1 and a request is active. The contents of `rd_data` in any other cycle have no effect on any output.
- R3: A single-word request completes after exactly one accepted acknowledge, for either slave width. `done` is 1 in the cycle after that acknowledge.
- R4: A line request to a narrow slave (`req_wide`=0) needs eight accepted acknowledges. `done` stays 0 after the first seven and is 1 in the cycle after the eighth.
- R5: A line request to a wide slave (`req_wide`=1) needs four accepted acknowledges. `done` is 1 in the cycle after the fourth.
- R6: For a narrow slave, `rd_waddr` bit 0 = 0 selects `rd_data[63:32]` and bit 0 = 1 selects `rd_data[31:0]`. The selected word is written to slot `rd_waddr`, and slot k of the line is `line_data[32k+31:32k]`.
- R7: For a wide slave, `rd_data[63:32]` is written to slot {`rd_waddr[2:1]`,0} and `rd_data[31:0]` to slot {`rd_waddr[2:1]`,1}. `rd_waddr[0]` has no effect on where the words go.
- R8: Slots may arrive in any order, with any number of idle cycles between acknowledges, and the finished line is still correct.
- R9: For a single-word request, the word is chosen as in R6 for both widths. Bit b of `req_be`, latched at the request, keeps bits [8b+7:8b] of `single_word`, and bytes that are not enabled read as 0. A single-word request leaves `line_data` unchanged.
- R10: An acknowledge with no request active is ignored. This includes an acknowledge in the cycle right after the last expected one: `done` does not pulse, and `line_data` and `single_word` do not change.
- R11: A `req_start` pulse clears the transfer count and latches `req_line`, `req_wide` and `req_be`, even in the middle of a request. An acknowledge in the same cycle as `req_start` is ignored.
- R12: `done` is high for exactly one cycle per completed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_start | input | 1 | One-cycle pulse that starts a request |
| req_line | input | 1 | 1 for an eight-word line, 0 for one word |
| req_wide | input | 1 | 1 when a 64-bit slave answers, 0 for a 32-bit slave |
| req_be | input | 4 | Byte enables for a single-word request |
| rd_ack | input | 1 | Read data acknowledge, one cycle per transfer |
| rd_data | input | 64 | Read data bus, upper half holds the even word |
| rd_waddr | input | 3 | Word address of the returned data |
| line_data | output | 256 | Assembled line, slot k at bits [32k+31:32k] |
| done | output | 1 | One-cycle completion pulse |
| single_word | output | 32 | Byte-masked result of a single-word request |

## Verification
The bench drives a narrow-slave line in four slot orders and a wide-slave line in three pair orders, with varying idle gaps. It puts deliberately different data on the bus half that should not be taken. A design that picked the half by anything other than address bit 0, or placed a wide pair by bit 0, would write the wrong slot contents. A design that counted the wrong number of transfers would pulse `done` early or late.

Single-word reads are swept over every word address and both widths, with many byte-enable patterns. This catches wrong byte masking and single reads that leak into the line. The bench also restarts a request in mid-line, with an acknowledge in the start cycle. It sends stray acknowledges, both with no request active and right after the last expected one. A design that counted these would finish one transfer early or corrupt stored slots.

// File: rtl/lfill_pkg.sv
package lfill_pkg;

  typedef struct packed {
    logic line;
    logic wide;
  } lfill_req_t;

  // Number of acknowledges a request needs.
  function automatic int unsigned xfer_total(input logic line, input logic wide,
                                             input int unsigned words);
    if (!line)
      return 1;
    else if (wide)
      return words / 2;
    else
      return words;
  endfunction

endpackage

// File: rtl/lfill_xfer_ctrl.sv
module lfill_xfer_ctrl #(
  parameter int LINE_WORDS = 8,
  localparam int CNT_W = $clog2(LINE_WORDS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic req_start,
  input  logic req_line,
  input  logic req_wide,
  input  logic rd_ack,
  output logic is_line,
  output logic is_wide,
  output logic accept,
  output logic done
);
  import lfill_pkg::*;

  lfill_req_t       req_q;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] expected;
  logic             last;

  assign is_line = req_q.line;
  assign is_wide = req_q.wide;

  // The start cycle has priority: an acknowledge that arrives with it is dropped.
  assign accept   = active & rd_ack & ~req_start;
  assign cnt_inc  = cnt + 1'b1;
  assign last     = accept && (cnt_inc == expected);

  always_comb begin
    expected = CNT_W'(xfer_total(req_q.line, req_q.wide, LINE_WORDS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= '0;
      active <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req_start) begin
        req_q.line <= req_line;
        req_q.wide <= req_wide;
        active     <= 1'b1;
        cnt        <= '0;
      end else if (accept) begin
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt_inc;
        end
      end
    end
  end

endmodule

// File: rtl/lfill_lane_sel.sv
module lfill_lane_sel #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int BUS_W  = 2 * WORD_W,
  localparam int ADDR_W = $clog2(LINE_WORDS)
) (
  input  logic [BUS_W-1:0]      rd_data,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic                  wide,
  output logic [WORD_W-1:0]     hi_word,
  output logic [WORD_W-1:0]     lo_word,
  output logic [WORD_W-1:0]     pick_word,
  output logic [LINE_WORDS-1:0] slot_mask
);

  // The upper half carries even word addresses and the lower half odd ones.
  assign hi_word   = rd_data[BUS_W-1:WORD_W];
  assign lo_word   = rd_data[WORD_W-1:0];
  assign pick_word = waddr[0] ? lo_word : hi_word;

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_mask
    localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(k);
    always_comb begin
      if (wide)
        slot_mask[k] = (SLOT[ADDR_W-1:1] == waddr[ADDR_W-1:1]);
      else
        slot_mask[k] = (SLOT == waddr);
    end
  end

endmodule

// File: rtl/lfill_line_store.sv
module lfill_line_store #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int LINE_BITS = WORD_W * LINE_WORDS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [LINE_WORDS-1:0] slot_mask,
  input  logic [WORD_W-1:0]     hi_word,
  input  logic [WORD_W-1:0]     lo_word,
  output logic [LINE_BITS-1:0]  line_data
);

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_slot
    logic [WORD_W-1:0] slot_q;
    logic [WORD_W-1:0] slot_d;

    // Even slots take the upper half of the bus and odd slots the lower half.
    if (k % 2 == 0) begin : g_even
      assign slot_d = hi_word;
    end else begin : g_odd
      assign slot_d = lo_word;
    end

    always_ff @(posedge clk) begin
      if (rst)
        slot_q <= '0;
      else if (wr_en && slot_mask[k])
        slot_q <= slot_d;
    end

    assign line_data[k*WORD_W +: WORD_W] = slot_q;
  end

endmodule

// File: rtl/lfill_assembler.sv
module lfill_assembler #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int BUS_W     = 2 * WORD_W,
  localparam int ADDR_W    = $clog2(LINE_WORDS),
  localparam int BYTES     = WORD_W / 8,
  localparam int LINE_BITS = WORD_W * LINE_WORDS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_start,
  input  logic                 req_line,
  input  logic                 req_wide,
  input  logic [BYTES-1:0]     req_be,
  input  logic                 rd_ack,
  input  logic [BUS_W-1:0]     rd_data,
  input  logic [ADDR_W-1:0]    rd_waddr,
  output logic [LINE_BITS-1:0] line_data,
  output logic                 done,
  output logic [WORD_W-1:0]    single_word
);

  logic                  is_line;
  logic                  is_wide;
  logic                  accept;
  logic [WORD_W-1:0]     hi_word;
  logic [WORD_W-1:0]     lo_word;
  logic [WORD_W-1:0]     pick_word;
  logic [LINE_WORDS-1:0] slot_mask;
  logic [BYTES-1:0]      be_q;
  logic [WORD_W-1:0]     be_mask;

  lfill_xfer_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .req_start(req_start),
    .req_line (req_line),
    .req_wide (req_wide),
    .rd_ack   (rd_ack),
    .is_line  (is_line),
    .is_wide  (is_wide),
    .accept   (accept),
    .done     (done)
  );

  lfill_lane_sel #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_lane (
    .rd_data  (rd_data),
    .waddr    (rd_waddr),
    .wide     (is_wide),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .pick_word(pick_word),
    .slot_mask(slot_mask)
  );

  lfill_line_store #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (accept & is_line),
    .slot_mask(slot_mask),
    .hi_word  (hi_word),
    .lo_word  (lo_word),
    .line_data(line_data)
  );

  for (genvar b = 0; b < BYTES; b++) begin : g_be
    assign be_mask[b*8 +: 8] = {8{be_q[b]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      be_q        <= '0;
      single_word <= '0;
    end else begin
      if (req_start)
        be_q <= req_be;
      if (accept && !is_line)
        single_word <= pick_word & be_mask;
    end
  end

endmodule

// File: rtl/lfill_assembler_chk.sv
module lfill_assembler_chk #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  localparam int LINE_BITS = WORD_W * LINE_WORDS,
  localparam int CNT_W     = $clog2(LINE_WORDS + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_start,
  input logic                 req_line,
  input logic                 req_wide,
  input logic                 rd_ack,
  input logic [LINE_BITS-1:0] line_data,
  input logic [WORD_W-1:0]    single_word,
  input logic                 done
);

  // Independent model of the request window.
  logic             m_open;
  logic             m_line;
  logic             m_wide;
  logic             m_fin;
  logic [CNT_W-1:0] m_cnt;
  logic [CNT_W-1:0] m_need;

  always_comb begin
    if (!m_line)
      m_need = CNT_W'(1);
    else if (m_wide)
      m_need = CNT_W'(LINE_WORDS / 2);
    else
      m_need = CNT_W'(LINE_WORDS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_open <= 1'b0;
      m_line <= 1'b0;
      m_wide <= 1'b0;
      m_fin  <= 1'b0;
      m_cnt  <= '0;
    end else begin
      m_fin <= 1'b0;
      if (req_start) begin
        m_open <= 1'b1;
        m_line <= req_line;
        m_wide <= req_wide;
        m_cnt  <= '0;
      end else if (m_open && rd_ack) begin
        if (m_cnt + 1'b1 == m_need) begin
          m_open <= 1'b0;
          m_fin  <= 1'b1;
        end else begin
          m_cnt <= m_cnt + 1'b1;
        end
      end
    end
  end

  AST_DONE_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
    m_fin |-> done);  // R4

  AST_DONE_ONLY_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
    done |-> m_fin);  // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R12

  AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (rst)
    !(m_open && rd_ack && !req_start) |=> $stable(line_data) && $stable(single_word));  // R10

  AST_SINGLE_KEEPS_LINE: assert property (@(posedge clk) disable iff (rst)
    (m_open && !m_line) |=> $stable(line_data));  // R9

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(rd_ack));  // R3

endmodule

bind lfill_assembler lfill_assembler_chk #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_start  (req_start),
  .req_line   (req_line),
  .req_wide   (req_wide),
  .rd_ack     (rd_ack),
  .line_data  (line_data),
  .single_word(single_word),
  .done       (done)
);

// File: tb/lfill_assembler_bench.sv
`timescale 1ns/1ps
module lfill_assembler_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_start = 1'b0;
  logic         req_line = 1'b0;
  logic         req_wide = 1'b0;
  logic [3:0]   req_be = '0;
  logic         rd_ack = 1'b0;
  logic [63:0]  rd_data = '0;
  logic [2:0]   rd_waddr = '0;
  logic [255:0] line_data;
  logic         done;
  logic [31:0]  single_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [31:0] exp_line [8];

  always #2 clk = ~clk;

  lfill_assembler u_lfill_assembler (
    .clk(clk), .rst(rst), .req_start(req_start), .req_line(req_line),
    .req_wide(req_wide), .req_be(req_be), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_waddr(rd_waddr), .line_data(line_data), .done(done), .single_word(single_word)
  );

  function automatic logic [31:0] wval(input int seed, input int slot);
    return 32'h1000_0000 * (slot + 1) + seed * 32'h0001_0203 + 32'h55;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_line(input string req);
    for (int k = 0; k < 8; k++)
      check(line_data[k*32 +: 32] == exp_line[k], req, 256'(line_data[k*32 +: 32]),
            256'(exp_line[k]));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      rd_data = {$urandom, $urandom};
      rd_waddr = 3'($urandom);
      @(posedge clk); #1;
    end
  endtask

  task automatic start(input bit line, input bit wide, input logic [3:0] be);
    req_start = 1'b1; req_line = line; req_wide = wide; req_be = be;
    rd_ack = 1'b0;
    @(posedge clk); #1;
    req_start = 1'b0;
    req_line = ~line; req_wide = ~wide; req_be = ~be;
  endtask

  task automatic ack(input logic [63:0] d, input logic [2:0] wa);
    rd_ack = 1'b1; rd_data = d; rd_waddr = wa;
    @(posedge clk); #1;
    rd_ack = 1'b0; rd_data = {$urandom, $urandom};
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // Narrow-slave line in a chosen slot order; the unused half carries other data.
  task automatic narrow_line(input int seed, input int pat);
    start(1'b1, 1'b0, 4'h0);
    for (int i = 0; i < 8; i++) begin
      int s;
      logic [31:0] w;
      case (pat)
        0: s = i;
        1: s = 7 - i;
        2: s = (i * 3 + 1) % 8;
        default: s = (i * 5 + 2) % 8;
      endcase
      w = wval(seed, s);
      idle((i + pat) % 3);
      ack((s % 2 == 0) ? {w, ~w} : {~w, w}, 3'(s));
      exp_line[s] = w;
      check(done == (i == 7), (i == 7) ? "R4 done after eighth" : "R4 no early done",
            256'(done), 256'(i == 7));
    end
    check_line("R6 R8 narrow line content");
  endtask

  task automatic wide_line(input int seed, input int pat);
    start(1'b1, 1'b1, 4'h0);
    for (int i = 0; i < 4; i++) begin
      int p;
      case (pat)
        0: p = i;
        1: p = 3 - i;
        default: p = (i * 3 + 1) % 4;
      endcase
      idle((i + pat) % 3);
      // Bit 0 of the address varies and must not move the pair.
      ack({wval(seed, 2*p), wval(seed, 2*p + 1)}, 3'(2*p + (i % 2)));
      exp_line[2*p]     = wval(seed, 2*p);
      exp_line[2*p + 1] = wval(seed, 2*p + 1);
      check(done == (i == 3), (i == 3) ? "R5 done after fourth" : "R5 no early done",
            256'(done), 256'(i == 3));
    end
    check_line("R7 R8 wide line content");
  endtask

  initial begin
    logic [255:0] line_snap;
    logic [31:0]  single_snap;
    for (int k = 0; k < 8; k++) exp_line[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b0, "R1 done reset", 256'(done), 256'(0));
    check(single_word == 32'h0, "R1 single reset", 256'(single_word), 256'(0));
    rst = 1'b0;
    check_line("R1 line reset");

    // R10: acknowledge with nothing active.
    ack(64'hDEAD_BEEF_0BAD_F00D, 3'd2);
    check(done == 1'b0, "R10 idle ack no done", 256'(done), 256'(0));
    check_line("R10 idle ack keeps line");

    for (int pat = 0; pat < 4; pat++) begin
      narrow_line(pat + 1, pat);
      // R10: an acknowledge right after the last one is ignored.
      ack(64'hFFFF_FFFF_FFFF_FFFF, 3'd0);
      check(done == 1'b0, "R12 done single cycle", 256'(done), 256'(0));
      check_line("R10 late ack ignored");
    end
    for (int pat = 0; pat < 3; pat++) begin
      wide_line(pat + 11, pat);
      idle(1);
      check(done == 1'b0, "R12 done single cycle", 256'(done), 256'(0));
    end

    // R3 / R9: single-word sweep over both widths, all addresses, varied enables.
    for (int wide = 0; wide < 2; wide++) begin
      for (int wa = 0; wa < 8; wa++) begin
        for (int v = 0; v < 3; v++) begin
          logic [3:0]  be;
          logic [31:0] hi, lo, pick, mask;
          be = (v == 2) ? 4'hF : 4'((wa * 3 + wide * 5 + v * 7) % 16);
          hi = wval(wa + 40 * v, 2 * wide);
          lo = ~wval(wa + 17 * v, 3);
          start(1'b0, wide[0], be);
          idle(v);
          ack({hi, lo}, 3'(wa));
          pick = (wa % 2 == 1) ? lo : hi;
          for (int b = 0; b < 4; b++) mask[b*8 +: 8] = {8{be[b]}};
          check(done == 1'b1, "R3 single done", 256'(done), 256'(1));
          check(single_word == (pick & mask), "R9 single word masked",
                256'(single_word), 256'(pick & mask));
          check_line("R9 single keeps line");
          idle(1);
          check(done == 1'b0, "R12 done single cycle", 256'(done), 256'(0));
        end
      end
    end

    // R11: restart mid-line with an acknowledge in the start cycle.
    start(1'b1, 1'b0, 4'h0);
    for (int i = 0; i < 3; i++) begin
      ack({wval(90, i), wval(90, i)}, 3'(i));
      exp_line[i] = wval(90, i);
    end
    req_start = 1'b1; req_line = 1'b1; req_wide = 1'b0;
    rd_ack = 1'b1; rd_data = 64'h1234_5678_9ABC_DEF0; rd_waddr = 3'd3;
    @(posedge clk); #1;
    req_start = 1'b0; rd_ack = 1'b0;
    check(done == 1'b0, "R11 restart no done", 256'(done), 256'(0));
    check(line_data[3*32 +: 32] == exp_line[3], "R11 start-cycle ack ignored",
          256'(line_data[3*32 +: 32]), 256'(exp_line[3]));
    for (int i = 0; i < 8; i++) begin
      logic [31:0] w;
      w = wval(77, i);
      idle(i % 2);
      ack({w, w}, 3'(i));
      exp_line[i] = w;
      check(done == (i == 7), "R11 count restarted", 256'(done), 256'(i == 7));
    end
    check_line("R11 line after restart");

    // R2: a long stretch of bus noise without acknowledge.
    line_snap = line_data;
    single_snap = single_word;
    start(1'b1, 1'b1, 4'hF);
    idle(20);
    check(line_data == line_snap, "R2 noise ignored", line_data, line_snap);
    check(single_word == single_snap, "R2 noise keeps single", 256'(single_word),
          256'(single_snap));
    check(done == 1'b0, "R2 noise no done", 256'(done), 256'(0));

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

endmodule